// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a 16-bit timer. It holds a 16-bit compare value that the CPU accesses as two 8-bit registers over a simple byte bus. When the timer prescaler pulses its phase strobe, the block compares the stored value against the free-running counter. The strobe arrives once every four bus clocks. On equality it sets a compare flag and copies the programmed output-level bit into the pin latch. If the enable bit is set, it also requests an interrupt.

A 16-bit value cannot be updated in one byte write. Writing the high byte therefore suspends comparisons until the low byte follows, so a half-updated value never produces a match. Writing the low byte on its own never suspends them. The flag clears after a two-step handshake: software reads the status register while the flag is set, then writes the low compare byte. The compare bytes have no reset and the timer never alters them, so software may use them as scratch storage.

Top module: `ocu_top`

## Requirements
- R1: Address 0 holds the high compare byte and address 1 the low compare byte. Each reads back the last value written to it.
- R2: Reset does not change the compare bytes.
- R3: A compare happens only in a cycle where `tick` is 1. If the counter equals the compare value while `tick` is 0, the flag and the pin do not change.
- R4: On a tick where `count_i` equals {high, low}, `match_flag` becomes 1 and `pin_out` takes `out_level`, both one clock later.
- R5: `pin_out` keeps its value on every tick that does not match and between ticks.
- R6: `irq` is 1 exactly when `match_flag` and `irq_en` are both 1. It stays 1 until the flag is cleared.
- R7: A write to the high byte blocks every match until the next write to the low byte.
- R8: A write to only the low byte does not block matches.
- R9: Reading address 2 returns the status byte: bit 0 is the flag, bit 1 is the pin, and the other bits are 0. If address 2 is read while the flag is 1, the next write to address 1 clears the flag. A write to address 1 with no such prior read leaves the flag set.
- R10: Reset clears `match_flag`, `pin_out` and the compare block, so a match is taken on the first tick after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Compare phase strobe from the prescaler |
| count_i | input | 16 | Free-running counter value |
| cpu_addr | input | 2 | Register select: 0 high byte, 1 low byte, 2 status |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data, combinational from the selected register |
| out_level | input | 1 | Level copied to the pin on a match |
| irq_en | input | 1 | Compare interrupt enable |
| match_flag | output | 1 | Compare flag |
| pin_out | output | 1 | Output pin latch |
| irq | output | 1 | Interrupt request |

## Verification
If the compare block is stuck in the wrong state, the first matching tick shows it. A stuck block misses the flag and leaves the pin unchanged. A block that was never set lets a match through after a lone high-byte write. Either way the fault appears on `match_flag` one clock after that tick. A wrong clear-handshake state appears on the very next low-byte write: the flag either drops without a status read or survives a proper one. A corrupted compare byte appears on the next read of its address, or as a match at the wrong counter value during the offset sweep.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    typedef enum logic [1:0] {
        SEL_HI   = 2'd0,
        SEL_LO   = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // event-side state: flag, pin latch and clear-handshake arm
    typedef struct packed {
        logic flag;
        logic pin;
        logic armed;
    } evt_state_t;

endpackage

// File: rtl/ocu_regs.sv
module ocu_regs #(
    parameter int unsigned BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hi,
    input  logic            wr_lo,
    input  logic [BW-1:0]   wdata,
    output logic [2*BW-1:0] cmp_val,
    output logic            inhibit
);
    typedef struct packed {
        logic [BW-1:0] hi;
        logic [BW-1:0] lo;
    } store_t;

    store_t store_d, store_q;
    logic   inh_d, inh_q;

    always_comb begin
        store_d = store_q;
        inh_d   = inh_q;
        if (wr_hi) begin
            store_d.hi = wdata;
            inh_d      = 1'b1;
        end else if (wr_lo) begin
            store_d.lo = wdata;
            inh_d      = 1'b0;
        end
    end

    // compare bytes carry no reset
    always_ff @(posedge clk) begin
        store_q <= store_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inh_q <= 1'b0;
        else        inh_q <= inh_d;
    end

    assign cmp_val = {store_q.hi, store_q.lo};
    assign inhibit = inh_q;
endmodule

// File: rtl/ocu_event.sv
module ocu_event
    import ocu_pkg::*;
#(
    parameter int unsigned BW = 8,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] count_i,
    input  logic [CW-1:0] cmp_val,
    input  logic          inhibit,
    input  logic          level,
    input  logic          rd_stat,
    input  logic          wr_lo,
    output logic          flag,
    output logic          pin,
    output logic          armed
);
    localparam int unsigned NB = CW / BW;

    logic [NB-1:0] byte_eq;
    logic          hit;
    evt_state_t    st_d, st_q;

    for (genvar g = 0; g < NB; g++) begin : g_byte_cmp
        assign byte_eq[g] = (count_i[g*BW +: BW] == cmp_val[g*BW +: BW]);
    end

    assign hit = tick && !inhibit && (&byte_eq);

    always_comb begin
        st_d = st_q;
        if (rd_stat && st_q.flag) st_d.armed = 1'b1;
        if (wr_lo && st_q.armed) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (hit) begin
            st_d.flag = 1'b1;
            st_d.pin  = level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag  = st_q.flag;
    assign pin   = st_q.pin;
    assign armed = st_q.armed;
endmodule

// File: rtl/ocu_top.sv
module ocu_top
    import ocu_pkg::*;
#(
    parameter int unsigned BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [2*BW-1:0] count_i,
    input  logic [1:0]      cpu_addr,
    input  logic [BW-1:0]   cpu_wdata,
    input  logic            cpu_rd,
    input  logic            cpu_wr,
    output logic [BW-1:0]   cpu_rdata,
    input  logic            out_level,
    input  logic            irq_en,
    output logic            match_flag,
    output logic            pin_out,
    output logic            irq
);
    localparam int unsigned CW = 2 * BW;

    reg_sel_e      sel;
    logic          wr_hi, wr_lo, rd_stat;
    logic [CW-1:0] cmp_val;
    logic          inhibit, armed;

    assign sel     = reg_sel_e'(cpu_addr);
    assign wr_hi   = cpu_wr && (sel == SEL_HI);
    assign wr_lo   = cpu_wr && (sel == SEL_LO);
    assign rd_stat = cpu_rd && (sel == SEL_STAT);

    ocu_regs #(.BW(BW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wdata   (cpu_wdata),
        .cmp_val (cmp_val),
        .inhibit (inhibit)
    );

    ocu_event #(.BW(BW), .CW(CW)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .count_i (count_i),
        .cmp_val (cmp_val),
        .inhibit (inhibit),
        .level   (out_level),
        .rd_stat (rd_stat),
        .wr_lo   (wr_lo),
        .flag    (match_flag),
        .pin     (pin_out),
        .armed   (armed)
    );

    always_comb begin
        unique case (sel)
            SEL_HI:   cpu_rdata = cmp_val[CW-1:BW];
            SEL_LO:   cpu_rdata = cmp_val[BW-1:0];
            SEL_STAT: cpu_rdata = {{(BW-2){1'b0}}, pin_out, match_flag};
            default:  cpu_rdata = '0;
        endcase
    end

    assign irq = match_flag && irq_en;
endmodule

// File: rtl/ocu_chk.sv
module ocu_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic match_flag,
    input logic pin_out,
    input logic irq,
    input logic irq_en,
    input logic inhibit,
    input logic armed,
    input logic wr_lo
);
    // R3
    flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(tick));

    // R7
    no_match_while_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> !$past(inhibit));

    // R5
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(pin_out));

    // R6
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && match_flag));

    // R9
    clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(match_flag) |-> $past(wr_lo && armed));
endmodule

bind ocu_top ocu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .match_flag (match_flag),
    .pin_out    (pin_out),
    .irq        (irq),
    .irq_en     (irq_en),
    .inhibit    (inhibit),
    .armed      (armed),
    .wr_lo      (wr_lo)
);

// File: tb/tb_ocu_top.sv
module tb_ocu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] count_i = '0;
    logic [1:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        out_level = 1'b0;
    logic        irq_en = 1'b0;
    logic        match_flag, pin_out, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    ocu_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count_i(count_i),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .out_level(out_level),
        .irq_en(irq_en), .match_flag(match_flag), .pin_out(pin_out), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    // one compare slot: strobe for one clock, then three idle clocks
    task automatic tick4(input logic [15:0] c);
        @(negedge clk);
        count_i = c; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_flag(input logic [7:0] lo);
        logic [7:0] s;
        rd(2'd2, s);
        wr(2'd1, lo);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] vals [5];
        logic        exp_pin;
        vals = '{16'h0000, 16'hFFFF, 16'h1234, 16'h8001, 16'h00FF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 flag", match_flag, 0);
        check("R10 pin", pin_out, 0);
        check("R6 irq", irq, 0);

        // R1 readback sweep
        for (int v = 0; v < 256; v += 17) begin
            wr(2'd0, 8'(v));
            wr(2'd1, 8'(255 - v));
            rd(2'd0, r); check("R1 hi", r, v);
            rd(2'd1, r); check("R1 lo", r, 255 - v);
        end

        // R2 bytes survive reset
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
        do_reset();
        rd(2'd0, r); check("R2 hi", r, 8'hA5);
        rd(2'd1, r); check("R2 lo", r, 8'h3C);

        // R3 no compare without tick
        @(negedge clk); count_i = 16'hA53C;
        repeat (4) @(negedge clk);
        check("R3 flag", match_flag, 0);
        check("R3 pin", pin_out, 0);

        // R4/R5/R6 sweep of values and offsets
        exp_pin = 1'b0;
        for (int i = 0; i < 5; i++) begin
            wr(2'd0, vals[i][15:8]); wr(2'd1, vals[i][7:0]);
            for (int off = -3; off <= 3; off++) begin
                logic lv;
                lv = ((i + off) & 1) != 0;
                out_level = lv;
                irq_en = (off & 2) != 0;
                tick4(vals[i] + 16'(off));
                if (off == 0) exp_pin = lv;
                check("R4 flag", match_flag, off == 0);
                check("R5 pin", pin_out, exp_pin);
                check("R6 irq", irq, (off == 0) && irq_en);
                rd(2'd2, r);
                check("R9 status", r, {6'b0, exp_pin, off == 0});
                if (off == 0) begin
                    wr(2'd1, vals[i][7:0]);
                    check("R9 clear", match_flag, 0);
                end
            end
        end

        // R6 irq held until cleared, follows enable
        irq_en = 1'b1; out_level = 1'b1;
        tick4(16'h00FF);
        repeat (5) @(negedge clk);
        check("R6 held", irq, 1);
        irq_en = 1'b0; #1;
        check("R6 enable off", irq, 0);
        irq_en = 1'b1;

        // R9 low write without status read keeps flag
        wr(2'd1, 8'hFF);
        check("R9 no read", match_flag, 1);
        clear_flag(8'hFF);
        check("R9 seq", match_flag, 0);
        // status read while flag clear does not arm
        rd(2'd2, r);
        tick4(16'h00FF);
        wr(2'd1, 8'hFF);
        check("R9 read before set", match_flag, 1);
        clear_flag(8'hFF);

        // R7 high write blocks until low write
        wr(2'd0, 8'h12);
        tick4(16'h12FF);
        check("R7 blocked", match_flag, 0);
        tick4(16'h00FF);
        check("R7 blocked old", match_flag, 0);
        wr(2'd1, 8'h34);
        tick4(16'h1234);
        check("R7 resumed", match_flag, 1);
        clear_flag(8'h34);

        // R8 low-only write does not block
        wr(2'd1, 8'h56);
        tick4(16'h1256);
        check("R8 lo only", match_flag, 1);
        clear_flag(8'h56);

        // R10 reset clears block
        wr(2'd0, 8'h77);
        do_reset();
        check("R10 pin cleared", pin_out, 0);
        tick4(16'h7756);
        check("R10 unblocked", match_flag, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule